// File: doc/BRIEF.md
# Programmable Address-Window Chip Select with Wait Insertion

This block watches a bus address and turns it into active-low chip selects. There are two memory windows fixed to the ends of the address space: a low window that starts at address zero and a high window that ends at the top address. A third memory window can be placed anywhere and is split into four equal quarters. A group of seven peripheral selects covers seven adjacent fixed-size blocks that begin at one programmable base. Each window carries its own wait count of 0 to 3. For the matched window, the block holds the ready output low for that many cycles, so slow devices need no ready logic of their own.

Software programs the windows through a small register write port. On each address strobe the block takes the address, the memory/IO qualifier and the current settings. It then drives the matching select for the whole access. A three-state sequencer runs each access. `ST_IDLE` waits for a strobe. `IDLE_TO_WAIT` is taken when the matched wait count is non-zero and `IDLE_TO_LAST` when it is zero. `ST_WAIT` counts the wait cycles down with ready low. It stays put through `WAIT_HOLD` and leaves through `WAIT_TO_LAST` when the count reaches its last cycle. `ST_LAST` is the final cycle, with ready high and the select still driven. It returns through `LAST_TO_IDLE`, which releases the select.

Top module: `addr_chip_select`

## Requirements
- R1: All selects are active low and at most one is asserted at a time. The select of an access asserts in the cycle after the strobe cycle and stays asserted through the final (ready-high) cycle of the access. Every select is released in the cycle after that.
- R2: The low window (register select 0) covers addresses 0 up to 2^(MIN_SZ_LOG2+code) - 1. The register holds code in bits [3:0], enable in bit 4 and wait count in bits [6:5]. A code large enough to reach past the address space makes the window the whole space.
- R3: The high window (register select 1, same field layout as R2) covers the top 2^(MIN_SZ_LOG2+code) bytes and ends at the highest address.
- R4: The movable window (register select 2, layout as R2) has its base in register select 3. Bits [ADDR_W-MIN_SZ_LOG2-1:0] of that register give the base address from bit MIN_SZ_LOG2 upward. Base bits below the window size are ignored. Quarter k of the window drives mid_cs_no[k], with quarter 0 at the lowest addresses.
- R5: Peripheral select i covers the block of 2^PER_BLK_LOG2 bytes with block number base+i, for i from 0 to 6. The base block number is bits [ADDR_W-PER_BLK_LOG2-1:0] of register select 4.
- R6: Register select 5 controls the peripheral group. Bit 0 enables it, and bit 1 set means it decodes memory accesses while clear means I/O accesses. Bits [3:2] hold its wait count. The three memory windows answer only when mem_io_i is 1 (memory).
- R7: When windows overlap, the low window wins over the high window, the high window wins over the movable window, and the movable window wins over the peripherals.
- R8: ready stays low for exactly the matched window's wait count, starting in the cycle after the strobe. An access that matches nothing asserts no select and gets no wait cycles.
- R9: Settings and the address are captured at the strobe. Register writes and further strobes made during an access do not change that access's select or wait count. A write affects the next access.
- R10: After reset all selects are high and ready is high. Only the high window is enabled, with code UPPER_RST_CODE and 3 wait cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | ADDR_W | Bus address, sampled on the strobe |
| mem_io_i | input | 1 | 1 = memory access, 0 = I/O access |
| as_i | input | 1 | Address strobe, one cycle per access |
| cfg_we_i | input | 1 | Register write enable |
| cfg_sel_i | input | 3 | Register select |
| cfg_data_i | input | 16 | Register write data |
| low_cs_no | output | 1 | Low window select |
| up_cs_no | output | 1 | High window select |
| mid_cs_no | output | 4 | Movable window quarter selects |
| per_cs_no | output | 7 | Peripheral block selects |
| rdy_o | output | 1 | Ready, low during wait cycles |

## Verification
The bench builds the block with ADDR_W=12, MIN_SZ_LOG2=6 and PER_BLK_LOG2=4, which gives a 4096-byte space, 64-byte minimum windows and 16-byte peripheral blocks. At that size every address can be swept in both the memory and I/O spaces under several settings: the reset setting, an overlapping layout with a misaligned movable base, and a saturated low window with I/O peripherals. Each access is compared against an arithmetic model for select, wait count and release. Mid-access writes and strobes are driven by hand.

// File: rtl/cs_pkg.sv
package cs_pkg;

    typedef struct packed {
        logic       en;
        logic [3:0] code;
        logic [1:0] waits;
    } region_cfg_t;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_WAIT,
        ST_LAST
    } acc_state_t;

    localparam logic [2:0] REG_LOWER    = 3'd0;
    localparam logic [2:0] REG_UPPER    = 3'd1;
    localparam logic [2:0] REG_MID      = 3'd2;
    localparam logic [2:0] REG_MID_BASE = 3'd3;
    localparam logic [2:0] REG_PER_BASE = 3'd4;
    localparam logic [2:0] REG_PER_CTRL = 3'd5;

endpackage

// File: rtl/cs_cfg_regs.sv
module cs_cfg_regs
    import cs_pkg::*;
#(
    parameter int ADDR_W         = 20,
    parameter int MIN_SZ_LOG2    = 10,
    parameter int PER_BLK_LOG2   = 7,
    parameter int UPPER_RST_CODE = 0,
    localparam int MB_W = ADDR_W - MIN_SZ_LOG2,
    localparam int PB_W = ADDR_W - PER_BLK_LOG2
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              we_i,
    input  logic [2:0]        sel_i,
    input  logic [15:0]       data_i,
    output region_cfg_t       lower_o,
    output region_cfg_t       upper_o,
    output region_cfg_t       mid_o,
    output logic [MB_W-1:0]   mid_base_o,
    output logic [PB_W-1:0]   per_base_o,
    output logic              per_en_o,
    output logic              per_mem_o,
    output logic [1:0]        per_waits_o
);

    region_cfg_t wr_region;

    assign wr_region = '{en: data_i[4], code: data_i[3:0], waits: data_i[6:5]};

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            lower_o     <= '0;
            upper_o     <= '{en: 1'b1, code: 4'(UPPER_RST_CODE), waits: 2'd3};
            mid_o       <= '0;
            mid_base_o  <= '0;
            per_base_o  <= '0;
            per_en_o    <= 1'b0;
            per_mem_o   <= 1'b0;
            per_waits_o <= '0;
        end else if (we_i) begin
            case (sel_i)
                REG_LOWER:    lower_o    <= wr_region;
                REG_UPPER:    upper_o    <= wr_region;
                REG_MID:      mid_o      <= wr_region;
                REG_MID_BASE: mid_base_o <= data_i[MB_W-1:0];
                REG_PER_BASE: per_base_o <= data_i[PB_W-1:0];
                REG_PER_CTRL: begin
                    per_en_o    <= data_i[0];
                    per_mem_o   <= data_i[1];
                    per_waits_o <= data_i[3:2];
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/cs_addr_decode.sv
module cs_addr_decode
    import cs_pkg::*;
#(
    parameter int ADDR_W       = 20,
    parameter int MIN_SZ_LOG2  = 10,
    parameter int PER_BLK_LOG2 = 7,
    parameter int N_MID        = 4,
    parameter int N_PER        = 7,
    localparam int MB_W     = ADDR_W - MIN_SZ_LOG2,
    localparam int PB_W     = ADDR_W - PER_BLK_LOG2,
    localparam int LOG_W    = $clog2(ADDR_W + 1),
    localparam int QSH      = $clog2(N_MID),
    localparam int CODE_MAX = ADDR_W - MIN_SZ_LOG2
) (
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              is_mem_i,
    input  region_cfg_t       lower_i,
    input  region_cfg_t       upper_i,
    input  region_cfg_t       mid_i,
    input  logic [MB_W-1:0]   mid_base_i,
    input  logic [PB_W-1:0]   per_base_i,
    input  logic              per_en_i,
    input  logic              per_mem_i,
    input  logic [1:0]        per_waits_i,
    output logic              lo_hit_o,
    output logic              up_hit_o,
    output logic [N_MID-1:0]  mid_hit_o,
    output logic [N_PER-1:0]  per_hit_o,
    output logic [1:0]        waits_o
);

    localparam logic [ADDR_W-1:0] ONES = {ADDR_W{1'b1}};

    function automatic logic [LOG_W-1:0] span_log(input logic [3:0] code);
        if (int'(code) > CODE_MAX) return LOG_W'(ADDR_W);
        else return LOG_W'(MIN_SZ_LOG2 + int'(code));
    endfunction

    logic [LOG_W-1:0]  lo_log, up_log, mid_log;
    logic [ADDR_W-1:0] lo_mask, up_mask, mid_mask, mid_full, q_shift;
    logic              lo_raw, up_raw, mid_match, per_ok;
    logic [QSH-1:0]    qidx;
    logic [N_MID-1:0]  mid_raw;
    logic [N_PER-1:0]  per_raw;
    logic [PB_W-1:0]   blk_off;

    always_comb begin
        lo_log   = span_log(lower_i.code);
        up_log   = span_log(upper_i.code);
        mid_log  = span_log(mid_i.code);
        lo_mask  = ONES << lo_log;
        up_mask  = ONES << up_log;
        mid_mask = ONES << mid_log;
        mid_full = {mid_base_i, {MIN_SZ_LOG2{1'b0}}};

        lo_raw    = lower_i.en && is_mem_i && ((addr_i & lo_mask) == '0);
        up_raw    = upper_i.en && is_mem_i && ((addr_i & up_mask) == up_mask);
        mid_match = mid_i.en && is_mem_i && ((addr_i & mid_mask) == (mid_full & mid_mask));
        q_shift   = addr_i >> (mid_log - LOG_W'(QSH));
        qidx      = q_shift[QSH-1:0];

        blk_off = addr_i[ADDR_W-1:PER_BLK_LOG2] - per_base_i;
        per_ok  = per_en_i && (is_mem_i == per_mem_i);
    end

    for (genvar gm = 0; gm < N_MID; gm++) begin : g_mid
        assign mid_raw[gm] = mid_match && (qidx == QSH'(gm));
    end

    for (genvar gp = 0; gp < N_PER; gp++) begin : g_per
        assign per_raw[gp] = per_ok && (blk_off == PB_W'(gp));
    end

    always_comb begin
        lo_hit_o  = lo_raw;
        up_hit_o  = up_raw && !lo_raw;
        mid_hit_o = (lo_raw || up_raw) ? '0 : mid_raw;
        per_hit_o = (lo_raw || up_raw || (|mid_raw)) ? '0 : per_raw;
        if (lo_hit_o)        waits_o = lower_i.waits;
        else if (up_hit_o)   waits_o = upper_i.waits;
        else if (|mid_hit_o) waits_o = mid_i.waits;
        else if (|per_hit_o) waits_o = per_waits_i;
        else                 waits_o = 2'd0;
    end

endmodule

// File: rtl/cs_wait_fsm.sv
module cs_wait_fsm
    import cs_pkg::*;
#(
    parameter int N_SEL = 13
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             strobe_i,
    input  logic [N_SEL-1:0] hit_i,
    input  logic [1:0]       waits_i,
    output logic [N_SEL-1:0] sel_o,
    output logic             rdy_o
);

    acc_state_t state, nxt;
    logic [1:0] cnt;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) state <= ST_IDLE;
        else         state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE: if (strobe_i) nxt = (waits_i == 2'd0) ? ST_LAST : ST_WAIT;
            ST_WAIT: if (cnt == 2'd1) nxt = ST_LAST;
            ST_LAST: nxt = ST_IDLE;
            default: nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            sel_o <= '0;
            cnt   <= '0;
        end else begin
            unique case (state)
                ST_IDLE: if (strobe_i) begin
                    sel_o <= hit_i;
                    cnt   <= waits_i;
                end
                ST_WAIT: cnt   <= cnt - 2'd1;
                ST_LAST: sel_o <= '0;
                default: sel_o <= '0;
            endcase
        end
    end

    assign rdy_o = (state != ST_WAIT);

endmodule

// File: rtl/addr_chip_select.sv
module addr_chip_select
    import cs_pkg::*;
#(
    parameter int ADDR_W         = 20,
    parameter int MIN_SZ_LOG2    = 10,
    parameter int PER_BLK_LOG2   = 7,
    parameter int UPPER_RST_CODE = 0,
    parameter int N_MID          = 4,
    parameter int N_PER          = 7
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              mem_io_i,
    input  logic              as_i,
    input  logic              cfg_we_i,
    input  logic [2:0]        cfg_sel_i,
    input  logic [15:0]       cfg_data_i,
    output logic              low_cs_no,
    output logic              up_cs_no,
    output logic [N_MID-1:0]  mid_cs_no,
    output logic [N_PER-1:0]  per_cs_no,
    output logic              rdy_o
);

    localparam int MB_W  = ADDR_W - MIN_SZ_LOG2;
    localparam int PB_W  = ADDR_W - PER_BLK_LOG2;
    localparam int N_SEL = 2 + N_MID + N_PER;

    region_cfg_t       lower_cfg, upper_cfg, mid_cfg;
    logic [MB_W-1:0]   mid_base;
    logic [PB_W-1:0]   per_base;
    logic              per_en, per_mem;
    logic [1:0]        per_waits, hit_waits;
    logic              lo_hit, up_hit;
    logic [N_MID-1:0]  mid_hit;
    logic [N_PER-1:0]  per_hit;
    logic [N_SEL-1:0]  sel_q;

    cs_cfg_regs #(
        .ADDR_W(ADDR_W), .MIN_SZ_LOG2(MIN_SZ_LOG2),
        .PER_BLK_LOG2(PER_BLK_LOG2), .UPPER_RST_CODE(UPPER_RST_CODE)
    ) u_regs (
        .clk_i(clk_i), .rst_ni(rst_ni), .we_i(cfg_we_i), .sel_i(cfg_sel_i),
        .data_i(cfg_data_i), .lower_o(lower_cfg), .upper_o(upper_cfg),
        .mid_o(mid_cfg), .mid_base_o(mid_base), .per_base_o(per_base),
        .per_en_o(per_en), .per_mem_o(per_mem), .per_waits_o(per_waits)
    );

    cs_addr_decode #(
        .ADDR_W(ADDR_W), .MIN_SZ_LOG2(MIN_SZ_LOG2),
        .PER_BLK_LOG2(PER_BLK_LOG2), .N_MID(N_MID), .N_PER(N_PER)
    ) u_dec (
        .addr_i(addr_i), .is_mem_i(mem_io_i), .lower_i(lower_cfg),
        .upper_i(upper_cfg), .mid_i(mid_cfg), .mid_base_i(mid_base),
        .per_base_i(per_base), .per_en_i(per_en), .per_mem_i(per_mem),
        .per_waits_i(per_waits), .lo_hit_o(lo_hit), .up_hit_o(up_hit),
        .mid_hit_o(mid_hit), .per_hit_o(per_hit), .waits_o(hit_waits)
    );

    cs_wait_fsm #(.N_SEL(N_SEL)) u_fsm (
        .clk_i(clk_i), .rst_ni(rst_ni), .strobe_i(as_i),
        .hit_i({per_hit, mid_hit, up_hit, lo_hit}), .waits_i(hit_waits),
        .sel_o(sel_q), .rdy_o(rdy_o)
    );

    assign low_cs_no = ~sel_q[0];
    assign up_cs_no  = ~sel_q[1];
    assign mid_cs_no = ~sel_q[2 +: N_MID];
    assign per_cs_no = ~sel_q[2 + N_MID +: N_PER];

endmodule

// File: rtl/addr_chip_select_chk.sv
module addr_chip_select_chk #(
    parameter int N_MID = 4,
    parameter int N_PER = 7
) (
    input logic             clk_i,
    input logic             rst_ni,
    input logic             as_i,
    input logic             low_cs_no,
    input logic             up_cs_no,
    input logic [N_MID-1:0] mid_cs_no,
    input logic [N_PER-1:0] per_cs_no,
    input logic             rdy_o
);

    logic [N_MID+N_PER+1:0] act;
    logic                   any_act;
    logic [2:0]             low_run;

    assign act     = ~{per_cs_no, mid_cs_no, up_cs_no, low_cs_no};
    assign any_act = |act;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)            low_run <= '0;
        else if (!rdy_o)        low_run <= (low_run == 3'd7) ? low_run : low_run + 3'd1;
        else                    low_run <= '0;
    end

    // R1 and R7: one select at most
    p_one_select_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $onehot0(act));

    // R1: a select only turns on right after a strobe
    p_select_after_strobe_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(any_act) |-> $past(as_i));

    // R9: the select of an access does not move while waiting
    p_select_held_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !rdy_o |=> $stable(act));

    // R8: wait cycles only for an access that selected something
    p_wait_needs_select_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !rdy_o |-> any_act);

    // R8: never more than three wait cycles in a row
    p_wait_bound_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        low_run <= 3'd3);

endmodule

bind addr_chip_select addr_chip_select_chk #(.N_MID(N_MID), .N_PER(N_PER)) u_chk (
    .clk_i(clk_i), .rst_ni(rst_ni), .as_i(as_i), .low_cs_no(low_cs_no),
    .up_cs_no(up_cs_no), .mid_cs_no(mid_cs_no), .per_cs_no(per_cs_no), .rdy_o(rdy_o)
);

// File: tb/addr_chip_select_bench.sv
module addr_chip_select_bench;

    localparam int A  = 12;
    localparam int MN = 6;
    localparam int PB = 4;
    localparam int NS = 13;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [A-1:0]  addr = '0;
    logic          mio = 1'b0;
    logic          as = 1'b0;
    logic          we = 1'b0;
    logic [2:0]    rsel = '0;
    logic [15:0]   rdata = '0;
    logic          low_n, up_n, rdy;
    logic [3:0]    mid_n;
    logic [6:0]    per_n;

    int compared = 0;
    int mismatched = 0;

    int l_en = 0, l_code = 0, l_w = 0;
    int u_en = 1, u_code = 0, u_w = 3;
    int m_en = 0, m_code = 0, m_w = 0, m_base = 0;
    int p_en = 0, p_mem = 0, p_w = 0, p_base = 0;

    always #4 clk = ~clk;

    addr_chip_select #(.ADDR_W(A), .MIN_SZ_LOG2(MN), .PER_BLK_LOG2(PB), .UPPER_RST_CODE(0)) u_addr_chip_select (
        .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .mem_io_i(mio), .as_i(as),
        .cfg_we_i(we), .cfg_sel_i(rsel), .cfg_data_i(rdata),
        .low_cs_no(low_n), .up_cs_no(up_n), .mid_cs_no(mid_n), .per_cs_no(per_n), .rdy_o(rdy)
    );

    function automatic logic [NS-1:0] act_now();
        return ~{per_n, mid_n, up_n, low_n};
    endfunction

    function automatic int span(int code);
        int lg = MN + code;
        if (lg > A) lg = A;
        return 1 << lg;
    endfunction

    function automatic logic [NS-1:0] model(int a, int m, output int w);
        logic [NS-1:0] v = '0;
        int msz = span(m_code);
        int blk = a >> PB;
        bit lo = l_en != 0 && m != 0 && a < span(l_code);
        bit up = u_en != 0 && m != 0 && a >= (1 << A) - span(u_code);
        bit mm = m_en != 0 && m != 0 && (a / msz) == ((m_base << MN) / msz);
        bit pm = p_en != 0 && m == p_mem && blk >= p_base && blk < p_base + 7;
        w = 0;
        if (lo)      begin v[0] = 1'b1; w = l_w; end
        else if (up) begin v[1] = 1'b1; w = u_w; end
        else if (mm) begin v[2 + (a % msz) / (msz / 4)] = 1'b1; w = m_w; end
        else if (pm) begin v[6 + blk - p_base] = 1'b1; w = p_w; end
        return v;
    endfunction

    task automatic check(bit ok, string tag, string what, int act_v, int exp_v);
        compared++;
        if (!ok) begin
            mismatched++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act_v, exp_v);
        end
    endtask

    task automatic wr(logic [2:0] s, int d);
        @(negedge clk);
        we = 1'b1; rsel = s; rdata = 16'(d);
        @(negedge clk);
        we = 1'b0;
    endtask

    task automatic set_region(logic [2:0] s, int en, int code, int w);
        wr(s, (w << 5) | (en << 4) | code);
        case (s)
            3'd0: begin l_en = en; l_code = code; l_w = w; end
            3'd1: begin u_en = en; u_code = code; u_w = w; end
            default: begin m_en = en; m_code = code; m_w = w; end
        endcase
    endtask

    task automatic access(int a, int m, string tag);
        logic [NS-1:0] first, last, exp;
        int w, n;
        exp = model(a, m, w);
        @(negedge clk);
        addr = A'(a); mio = m[0]; as = 1'b1;
        @(negedge clk);
        as = 1'b0;
        first = act_now();
        n = 0;
        while (!rdy) begin n++; @(negedge clk); end
        last = act_now();
        @(negedge clk);
        check(first == exp && last == exp && n == w && act_now() == '0, tag,
              $sformatf("addr %0h mio %0d sel/waits", a, m),
              int'({first, 4'(n)}), int'({exp, 4'(w)}));
    endtask

    task automatic sweep(int m, string tag);
        for (int a = 0; a < (1 << A); a++) access(a, m, tag);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        mismatched++;
        $display("FAIL watchdog: actual hung expected done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        logic [NS-1:0] held;
        int n;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10: reset outputs idle
        check(act_now() == '0 && rdy, "R10", "reset outputs", int'({act_now(), rdy}), 1);

        // R10 R3 R8 R1: reset layout, full memory sweep and I/O sweep
        sweep(1, "R10/R3/R8");
        sweep(0, "R6/R8");

        // R2 R3 R4 R5 R7: overlapping layout, misaligned movable base (0x440 -> 0x400)
        set_region(3'd0, 1, 1, 1);
        set_region(3'd1, 1, 2, 3);
        set_region(3'd2, 1, 3, 2);
        wr(3'd3, 'h11); m_base = 'h11;
        wr(3'd4, 'h5F); p_base = 'h5F;
        wr(3'd5, 'b0011); p_en = 1; p_mem = 1; p_w = 0;
        sweep(1, "R2/R3/R4/R5/R7");
        sweep(0, "R6");

        // R2 R6: saturated low window, peripherals in I/O space
        set_region(3'd0, 1, 15, 2);
        set_region(3'd1, 0, 0, 0);
        set_region(3'd2, 0, 0, 0);
        wr(3'd4, 'h10); p_base = 'h10;
        wr(3'd5, 'b1101); p_en = 1; p_mem = 0; p_w = 3;
        sweep(1, "R2");
        sweep(0, "R6/R5");

        // R9: write and strobe during an access leave it unchanged
        set_region(3'd0, 0, 0, 0);
        set_region(3'd1, 1, 0, 3);
        @(negedge clk);
        addr = A'('hFF0); mio = 1'b1; as = 1'b1;
        @(negedge clk);
        as = 1'b0;
        held = act_now();
        we = 1'b1; rsel = 3'd1; rdata = 16'h0000;
        addr = '0; as = 1'b1;
        @(negedge clk);
        we = 1'b0; as = 1'b0;
        n = 1;
        check(act_now() == held && held == 13'b10, "R9", "select during access",
              int'(act_now()), int'(held));
        while (!rdy) begin n++; @(negedge clk); end
        check(n == 3, "R9", "waits during access", n, 3);
        @(negedge clk);
        check(act_now() == '0, "R1", "release after access", int'(act_now()), 0);
        u_en = 0; u_code = 0; u_w = 0;
        // R9: the write applies to the next access
        access('hFF0, 1, "R9");
        access('h105, 0, "R9/R5");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

endmodule